// File: doc/BRIEF.md
# Strobe-Handshake FIFO with Level Flags

This block is a first-in first-out word buffer, 64 words deep and 9 bits wide by default, with an 8-bit build selected by a parameter. A producer pulses a shift-in strobe for one clock while the block shows input-ready, and the word on the data input is stored. A consumer sees output-ready whenever a word sits at the head and pulses a shift-out strobe to move on to the next word. Strobes that arrive while the matching ready signal is low are dropped.

Two level flags are decoded from the stored word count. The edge flag is high when the buffer is nearly drained or nearly filled. The half flag is high from the midpoint upward. Read together, the two flags place the fill level in one of four bands. An asynchronous master clear empties the buffer. An output enable forces the data output to zero without touching the read position.

A three-state control machine tracks the fill condition. The states are `ST_EMPTY`, `ST_PARTIAL` and `ST_FULL`. A write in `ST_EMPTY` moves the machine to `ST_PARTIAL`. In `ST_PARTIAL`, a read of the last word without a write returns it to `ST_EMPTY`. In `ST_PARTIAL`, a write that fills the last slot without a read moves it to `ST_FULL`. A read in `ST_FULL` returns it to `ST_PARTIAL`. All other cases hold the state, including both strobes together in `ST_PARTIAL`. The master clear forces `ST_EMPTY`.

Top module: `strobe_fifo`

## Requirements
- R1: While and after `mst_clr` is high, `out_rdy`=0, `in_rdy`=1, `near_edge`=1 and `half_lvl`=0, and the buffer holds no words.
- R2: A `shift_in` pulse stores `din` only while `in_rdy` is high. With 64 words stored, `in_rdy` is 0 and a `shift_in` pulse changes neither the contents nor the flags.
- R3: With no words stored, `out_rdy` is 0 and a `shift_out` pulse has no effect: `out_rdy` stays 0 and the flags keep their empty-band values.
- R4: Words appear on `dout` in the order they were written. Each accepted `shift_out` pulse exposes the next word after the following rising edge.
- R5: With 0 to 8 words stored, `near_edge`=1 and `half_lvl`=0.
- R6: With 9 to 31 words stored, `near_edge`=0 and `half_lvl`=0.
- R7: With 32 to 55 words stored, `near_edge`=0 and `half_lvl`=1.
- R8: With 56 to 64 words stored, `near_edge`=1 and `half_lvl`=1.
- R9: A word written into an empty buffer is on `dout`, with `out_rdy`=1, right after the rising edge that samples the strobe.
- R10: Pulses on `shift_in` and `shift_out` in the same cycle, with between 1 and 63 words stored, leave the count unchanged. They drop the head word and append the new one.
- R11: While `out_en` is 0, `dout` is all zeros. The read position is kept, so the same head word returns when `out_en` goes back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| mst_clr | input | 1 | Asynchronous master clear, active high |
| shift_in | input | 1 | One-cycle write strobe |
| din | input | WIDTH | Word to store |
| in_rdy | output | 1 | Buffer can accept a word |
| shift_out | input | 1 | One-cycle strobe to advance past the head word |
| dout | output | WIDTH | Head word, or zero while output is disabled |
| out_rdy | output | 1 | A word is present on the output |
| out_en | input | 1 | Output enable, active high |
| near_edge | output | 1 | Level is within the low or high edge band |
| half_lvl | output | 1 | Level is at or above the midpoint |

## Verification
The assertions assume that `shift_in` and `shift_out` are synchronous to `clk` and stable around each rising edge. They also assume the clear is held long enough for the state to settle, and they are silent while it is high. The bench changes every input only on falling edges and keeps each strobe high for exactly one cycle. It releases the clear on a falling edge, so every sampled edge sees clean levels. It drives the fill level through every band boundary in both directions, then exercises the full, empty, simultaneous-strobe and disabled-output cases directly.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } fill_state_t;

endpackage

// File: rtl/strobe_fifo_ctrl.sv
module strobe_fifo_ctrl
    import strobe_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          mst_clr,
    input  logic          shift_in,
    input  logic          shift_out,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] level,
    output logic          in_rdy,
    output logic          out_rdy
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [CW-1:0] LAST_FREE = CW'(DEPTH - 1);

    fill_state_t state_q, state_d;
    logic        rd_en;

    // Accepted strobes depend only on the registered fill state
    always_comb begin
        wr_en = shift_in  && (state_q != ST_FULL);
        rd_en = shift_out && (state_q != ST_EMPTY);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (wr_en) state_d = ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (rd_en && !wr_en && level == CW'(1))
                    state_d = ST_EMPTY;
                else if (wr_en && !rd_en && level == LAST_FREE)
                    state_d = ST_FULL;
            end
            ST_FULL: begin
                if (rd_en) state_d = ST_PARTIAL;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or posedge mst_clr) begin
        if (mst_clr) state_q <= ST_EMPTY;
        else         state_q <= state_d;
    end

    // Pointers and word count
    always_ff @(posedge clk or posedge mst_clr) begin
        if (mst_clr) begin
            wr_addr <= '0;
            rd_addr <= '0;
            level   <= '0;
        end else begin
            if (wr_en)
                wr_addr <= (wr_addr == LAST_ADDR) ? '0 : wr_addr + AW'(1);
            if (rd_en)
                rd_addr <= (rd_addr == LAST_ADDR) ? '0 : rd_addr + AW'(1);
            if (wr_en && !rd_en)
                level <= level + CW'(1);
            else if (rd_en && !wr_en)
                level <= level - CW'(1);
        end
    end

    // Handshake outputs from state
    always_comb begin
        in_rdy  = 1'b1;
        out_rdy = 1'b0;
        unique case (state_q)
            ST_EMPTY:   begin in_rdy = 1'b1; out_rdy = 1'b0; end
            ST_PARTIAL: begin in_rdy = 1'b1; out_rdy = 1'b1; end
            ST_FULL:    begin in_rdy = 1'b0; out_rdy = 1'b1; end
            default:    begin in_rdy = 1'b0; out_rdy = 1'b0; end
        endcase
    end

endmodule

// File: rtl/strobe_fifo_mem.sv
module strobe_fifo_mem #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    // Combinational read gives fall-through of the head word
    assign rd_data = store[rd_addr];

endmodule

// File: rtl/strobe_fifo_flags.sv
module strobe_fifo_flags #(
    parameter int CW      = 7,
    parameter int LOW_MAX = 8,
    parameter int MID_MIN = 32,
    parameter int HIGH_MIN = 56
) (
    input  logic [CW-1:0] level,
    output logic          near_edge,
    output logic          half_lvl
);

    localparam logic [CW-1:0] LOW_LIM  = CW'(LOW_MAX);
    localparam logic [CW-1:0] MID_LIM  = CW'(MID_MIN);
    localparam logic [CW-1:0] HIGH_LIM = CW'(HIGH_MIN);

    always_comb begin
        near_edge = (level <= LOW_LIM) || (level >= HIGH_LIM);
        half_lvl  = (level >= MID_LIM);
    end

endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo #(
    parameter int WIDTH    = 9,
    parameter int DEPTH    = 64,
    parameter int LOW_MAX  = 8,
    parameter int MID_MIN  = 32,
    parameter int HIGH_MIN = 56
) (
    input  logic             clk,
    input  logic             mst_clr,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] din,
    output logic             in_rdy,
    input  logic             shift_out,
    output logic [WIDTH-1:0] dout,
    output logic             out_rdy,
    input  logic             out_en,
    output logic             near_edge,
    output logic             half_lvl
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic             wr_en;
    logic [AW-1:0]    wr_addr;
    logic [AW-1:0]    rd_addr;
    logic [CW-1:0]    level;
    logic [WIDTH-1:0] head;

    strobe_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .mst_clr   (mst_clr),
        .shift_in  (shift_in),
        .shift_out (shift_out),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .level     (level),
        .in_rdy    (in_rdy),
        .out_rdy   (out_rdy)
    );

    strobe_fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (din),
        .rd_addr (rd_addr),
        .rd_data (head)
    );

    strobe_fifo_flags #(
        .CW(CW), .LOW_MAX(LOW_MAX), .MID_MIN(MID_MIN), .HIGH_MIN(HIGH_MIN)
    ) u_flags (
        .level     (level),
        .near_edge (near_edge),
        .half_lvl  (half_lvl)
    );

    assign dout = out_en ? head : '0;

endmodule

// File: rtl/strobe_fifo_chk.sv
module strobe_fifo_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input logic          clk,
    input logic          mst_clr,
    input logic          shift_in,
    input logic          shift_out,
    input logic          in_rdy,
    input logic          out_rdy,
    input logic          near_edge,
    input logic          half_lvl,
    input logic [CW-1:0] level
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (mst_clr)
        level <= CW'(DEPTH)); // R2

    AST_FULL_DROPS_WRITE: assert property (@(posedge clk) disable iff (mst_clr)
        (!in_rdy && shift_in && !shift_out) |=> !in_rdy); // R2

    AST_EMPTY_DROPS_READ: assert property (@(posedge clk) disable iff (mst_clr)
        (!out_rdy && shift_out && !shift_in) |=> (!out_rdy && near_edge && !half_lvl)); // R3

    AST_EMPTY_BAND: assert property (@(posedge clk) disable iff (mst_clr)
        !out_rdy |-> (near_edge && !half_lvl)); // R5

    AST_FULL_BAND: assert property (@(posedge clk) disable iff (mst_clr)
        !in_rdy |-> (near_edge && half_lvl)); // R8

    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (mst_clr)
        (!out_rdy && shift_in) |=> out_rdy); // R9

    AST_RISE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (mst_clr)
        $rose(out_rdy) |-> $past(shift_in)); // R9

    AST_BOTH_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (mst_clr)
        (in_rdy && out_rdy && shift_in && shift_out) |=> $stable(level)); // R10

endmodule

bind strobe_fifo strobe_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .mst_clr   (mst_clr),
    .shift_in  (shift_in),
    .shift_out (shift_out),
    .in_rdy    (in_rdy),
    .out_rdy   (out_rdy),
    .near_edge (near_edge),
    .half_lvl  (half_lvl),
    .level     (level)
);

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;

    localparam int W = 9;
    localparam int DEPTH = 64;

    // Entry: [8:2] target level, [1] expected near_edge, [0] expected half_lvl
    localparam logic [8:0] VEC [14] = '{
        {7'd8,  1'b1, 1'b0}, {7'd9,  1'b0, 1'b0}, {7'd31, 1'b0, 1'b0},
        {7'd32, 1'b0, 1'b1}, {7'd55, 1'b0, 1'b1}, {7'd56, 1'b1, 1'b1},
        {7'd64, 1'b1, 1'b1}, {7'd56, 1'b1, 1'b1}, {7'd55, 1'b0, 1'b1},
        {7'd32, 1'b0, 1'b1}, {7'd31, 1'b0, 1'b0}, {7'd9,  1'b0, 1'b0},
        {7'd8,  1'b1, 1'b0}, {7'd0,  1'b1, 1'b0}
    };

    logic         clk = 1'b0;
    logic         mst_clr = 1'b1;
    logic         shift_in = 1'b0;
    logic         shift_out = 1'b0;
    logic [W-1:0] din = '0;
    logic         out_en = 1'b1;
    logic         in_rdy, out_rdy, near_edge, half_lvl;
    logic [W-1:0] dout;

    int total = 0;
    int bad = 0;
    logic [W-1:0] q [$];
    logic [W-1:0] pat = 9'h100;

    always #10 clk = ~clk;

    strobe_fifo #(.WIDTH(W), .DEPTH(DEPTH)) u_strobe_fifo (
        .clk(clk), .mst_clr(mst_clr), .shift_in(shift_in), .din(din),
        .in_rdy(in_rdy), .shift_out(shift_out), .dout(dout), .out_rdy(out_rdy),
        .out_en(out_en), .near_edge(near_edge), .half_lvl(half_lvl)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic si, input logic so, input logic [W-1:0] d);
        logic rd, wr;
        @(negedge clk);
        shift_in = si; shift_out = so; din = d;
        if (so && q.size() > 0) check("R4 head word", dout, q[0]);
        rd = so && (q.size() > 0);
        wr = si && (q.size() < DEPTH);
        @(negedge clk);
        shift_in = 1'b0; shift_out = 1'b0;
        if (rd) void'(q.pop_front());
        if (wr) q.push_back(d);
    endtask

    function automatic string band_tag(input int lvl);
        if (lvl <= 8)  return "R5";
        if (lvl <= 31) return "R6";
        if (lvl <= 55) return "R7";
        return "R8";
    endfunction

    task automatic check_reset_state();
        check("R1 out_rdy", out_rdy, 0);
        check("R1 in_rdy", in_rdy, 1);
        check("R1 near_edge", near_edge, 1);
        check("R1 half_lvl", half_lvl, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();
        mst_clr = 1'b0;
        @(negedge clk);
        check_reset_state();

        // Level walk through every band edge, both directions (R5 R6 R7 R8)
        for (int i = 0; i < 14; i++) begin
            int lvl;
            lvl = int'(VEC[i][8:2]);
            while (q.size() < lvl) begin
                step(1'b1, 1'b0, pat);
                pat = pat + 9'd37;
            end
            while (q.size() > lvl) step(1'b0, 1'b1, '0);
            check({band_tag(lvl), " near_edge"}, near_edge, VEC[i][1]);
            check({band_tag(lvl), " half_lvl"}, half_lvl, VEC[i][0]);
            check("R2 in_rdy", in_rdy, (lvl != DEPTH) ? 1 : 0);
            check("R3 out_rdy", out_rdy, (lvl != 0) ? 1 : 0);
        end

        // R3: read on empty is dropped
        step(1'b0, 1'b1, '0);
        check("R3 out_rdy after empty read", out_rdy, 0);
        check("R3 near_edge after empty read", near_edge, 1);
        check("R3 half_lvl after empty read", half_lvl, 0);

        // R9: fall-through into empty buffer
        step(1'b1, 1'b0, 9'h1A5);
        check("R9 out_rdy", out_rdy, 1);
        check("R9 dout", dout, 9'h1A5);

        // R2: fill, then an extra write must be dropped
        while (q.size() < DEPTH) begin
            step(1'b1, 1'b0, pat);
            pat = pat + 9'd11;
        end
        step(1'b1, 1'b0, 9'h0FF);
        check("R2 in_rdy when full", in_rdy, 0);
        check("R2 flags when full", {near_edge, half_lvl}, 2'b11);
        while (q.size() > 20) step(1'b0, 1'b1, '0);

        // R10: simultaneous strobes keep the level
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 1'b1, 9'h033 + 9'(k));
            check("R10 in_rdy", in_rdy, 1);
            check("R10 out_rdy", out_rdy, 1);
            check("R10 flags", {near_edge, half_lvl}, 2'b00);
        end
        while (q.size() > 9) step(1'b0, 1'b1, '0);
        check("R10 level still above low band", near_edge, 0);

        // R11: disabled output reads zero and keeps the head
        @(negedge clk);
        out_en = 1'b0;
        @(negedge clk);
        check("R11 dout disabled", dout, 0);
        @(negedge clk);
        out_en = 1'b1;
        @(negedge clk);
        check("R11 head kept", dout, q[0]);
        while (q.size() > 0) step(1'b0, 1'b1, '0);
        check("R4 drained", out_rdy, 0);

        // R1: clear during operation
        step(1'b1, 1'b0, 9'h055);
        step(1'b1, 1'b0, 9'h0AA);
        @(negedge clk);
        mst_clr = 1'b1;
        @(negedge clk);
        check_reset_state();
        mst_clr = 1'b0;
        q.delete();
        @(negedge clk);
        check_reset_state();
        step(1'b1, 1'b0, 9'h0C3);
        check("R1 first word after clear", dout, 9'h0C3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule